// File: doc/BRIEF.md
# Sub-Second Prescaler with Fractional Shift

This block is the synchronous stage of a real-time clock prescaler. It takes an enable that pulses once per prescaled tick, counts a sub-second value down from a programmable reload, and produces a one-cycle second strobe each time the count wraps through zero. The calendar that consumes the strobe, the asynchronous divider in front of it and the bus decoding around it live elsewhere.

Software can trim the phase of the second boundary against a more accurate remote clock. It writes a shift value and an optional add-one-second flag. The block then adds the shift value to the live count on the next tick, so the boundary is pushed back by that many ticks. When the flag is set, a one-cycle pulse also tells the calendar to step one second forward, so the net effect is an earlier boundary. A pending flag covers the time from an accepted write until the shift is applied.

Two synchronous active-high resets are used. The system reset only clears the output pulses, so the count and the pending shift carry on across it. The backup reset stops the counter and clears everything the block holds.

Top module: `rtc_subsec_shift`

## Requirements
- R1: While `tick` is low, `ssc` holds its value. Each cycle with `tick` high and no shift applied, a non-zero `ssc` drops by exactly one.
- R2: A tick seen with `ssc` equal to 0 loads `factor_s` (zero-extended) into `ssc` and raises `sec_stb` for one cycle in the next cycle. Without shifts, consecutive strobes are `factor_s`+1 ticks apart.
- R3: A write (`shift_wr` high) is accepted when `ref_en` is 0, `shift_pend` is 0 and `ssc` bit 15 is 0. An accepted write raises `shift_pend` in the next cycle.
- R4: On the first tick while `shift_pend` is 1, the value added to `ssc` is the stored shift, on top of the normal step (`ssc`-1, or the reload when `ssc` is 0). `shift_pend` clears in the same cycle. With the add-second flag clear, the strobe after the write comes `factor_s`+1+shift ticks after the one before.
- R5: With the add-second flag set, the same addition is made and `add_sec` pulses for one cycle, in the cycle after the applying tick.
- R6: A write made while `ref_en` is 1 is ignored. `shift_pend` stays 0 and the strobe period is unchanged.
- R7: A write made while `ssc` bit 15 is 1 is ignored, and `shift_pend` stays 0.
- R8: A write made while `shift_pend` is 1 is ignored. The first accepted shift value is the one applied.
- R9: The system reset leaves `ssc` and `shift_pend` unchanged and clears `sec_stb` and `add_sec`. A pending shift is still applied after the reset.
- R10: The backup reset forces `ssc` to 0 and `shift_pend` to 0, holds `ssc` at 0 while it is asserted even with ticks arriving, and discards any stored shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sys_rst | input | 1 | System reset, synchronous active-high; clears the output pulses only |
| bkp_rst | input | 1 | Backup reset, synchronous active-high; clears all state |
| tick | input | 1 | Prescaled tick enable |
| factor_s | input | 15 | Reload value of the sub-second counter |
| ref_en | input | 1 | Reference-clock mode; blocks shift writes when 1 |
| shift_wr | input | 1 | Shift register write strobe |
| shift_sfs | input | 15 | Shift value, in ticks |
| shift_a1s | input | 1 | Add-one-second flag of the write |
| ssc | output | 16 | Live sub-second count |
| sec_stb | output | 1 | One-cycle second strobe |
| add_sec | output | 1 | One-cycle add-a-second pulse to the calendar |
| shift_pend | output | 1 | Shift accepted and not yet applied |

## Verification
The bench builds the block with its default 16-bit count and drives a tick every cycle. It uses small reload values of 20 and 7, so that each second period, stretched by a shift or not, is measured exactly in cycles. A large shift value of 0x7FF0 lifts the count past bit 15, which brings the rejection of writes on a high count within reach. The backup reset then brings the count back without waiting for a full 32K-tick countdown.

// File: rtl/rtc_shift_pkg.sv
package rtc_shift_pkg;
  localparam int unsigned CNT_W_DEF = 16;

  typedef struct packed {
    logic        a1s;
    logic [14:0] sfs;
  } shift_req_t;
endpackage

// File: rtl/rtc_shift_ctrl.sv
module rtc_shift_ctrl #(
  parameter int unsigned CNT_W = rtc_shift_pkg::CNT_W_DEF,
  localparam int unsigned OFS_W = CNT_W - 1
) (
  input  logic             clk,
  input  logic             bkp_rst,
  input  logic             tick,
  input  logic             ref_en,
  input  logic             cnt_msb,
  input  logic             wr,
  input  logic [OFS_W-1:0] wr_sfs,
  input  logic             wr_a1s,
  output logic             pend,
  output logic [OFS_W-1:0] sfs_q,
  output logic             a1s_q
);
  logic accept;

  assign accept = wr && !ref_en && !pend && !cnt_msb;

  always_ff @(posedge clk) begin
    if (bkp_rst) begin
      pend  <= 1'b0;
      sfs_q <= '0;
      a1s_q <= 1'b0;
    end else if (accept) begin
      pend  <= 1'b1;
      sfs_q <= wr_sfs;
      a1s_q <= wr_a1s;
    end else if (tick && pend) begin
      pend <= 1'b0;
    end
  end

  // R3
  pend_set_chk: assert property (@(posedge clk) disable iff (bkp_rst)
    wr && !ref_en && !pend && !cnt_msb |=> pend);
  // R6
  refen_block_chk: assert property (@(posedge clk) disable iff (bkp_rst)
    wr && ref_en && !pend |=> !pend);
  // R7
  msb_block_chk: assert property (@(posedge clk) disable iff (bkp_rst)
    wr && cnt_msb && !pend |=> !pend);
  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (bkp_rst)
    pend && !tick |=> pend && $stable(sfs_q) && $stable(a1s_q));
endmodule

// File: rtl/rtc_subsec_cnt.sv
module rtc_subsec_cnt #(
  parameter int unsigned CNT_W = rtc_shift_pkg::CNT_W_DEF,
  localparam int unsigned OFS_W = CNT_W - 1
) (
  input  logic             clk,
  input  logic             sys_rst,
  input  logic             bkp_rst,
  input  logic             tick,
  input  logic [OFS_W-1:0] reload,
  input  logic             pend,
  input  logic [OFS_W-1:0] sfs,
  input  logic             a1s,
  output logic [CNT_W-1:0] cnt,
  output logic             stb,
  output logic             add1
);
  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] offset;
  logic             wrap;

  assign wrap   = (cnt == '0);
  assign base   = wrap ? {1'b0, reload} : cnt - 1'b1;
  assign offset = pend ? {1'b0, sfs} : '0;

  always_ff @(posedge clk) begin
    if (bkp_rst) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= base + offset;
    end
  end

  always_ff @(posedge clk) begin
    if (bkp_rst || sys_rst) begin
      stb  <= 1'b0;
      add1 <= 1'b0;
    end else begin
      stb  <= tick && wrap;
      add1 <= tick && pend && a1s;
    end
  end

  // R1
  hold_chk: assert property (@(posedge clk) disable iff (bkp_rst)
    !tick |=> $stable(cnt));
  // R2
  wrap_chk: assert property (@(posedge clk) disable iff (bkp_rst || sys_rst)
    tick && cnt == '0 && !pend |=> stb && cnt == {1'b0, $past(reload)});
  // R4
  shift_add_chk: assert property (@(posedge clk) disable iff (bkp_rst)
    tick && pend && cnt != '0 |=> cnt == $past(cnt) - 1'b1 + {1'b0, $past(sfs)});
  // R10
  bkp_clear_chk: assert property (@(posedge clk)
    bkp_rst |=> cnt == '0 && !stb && !add1);
endmodule

// File: rtl/rtc_subsec_shift.sv
module rtc_subsec_shift #(
  parameter int unsigned CNT_W = rtc_shift_pkg::CNT_W_DEF,
  localparam int unsigned OFS_W = CNT_W - 1
) (
  input  logic             clk,
  input  logic             sys_rst,
  input  logic             bkp_rst,
  input  logic             tick,
  input  logic [OFS_W-1:0] factor_s,
  input  logic             ref_en,
  input  logic             shift_wr,
  input  logic [OFS_W-1:0] shift_sfs,
  input  logic             shift_a1s,
  output logic [CNT_W-1:0] ssc,
  output logic             sec_stb,
  output logic             add_sec,
  output logic             shift_pend
);
  logic [OFS_W-1:0] sfs_q;
  logic             a1s_q;

  rtc_shift_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk     (clk),
    .bkp_rst (bkp_rst),
    .tick    (tick),
    .ref_en  (ref_en),
    .cnt_msb (ssc[CNT_W-1]),
    .wr      (shift_wr),
    .wr_sfs  (shift_sfs),
    .wr_a1s  (shift_a1s),
    .pend    (shift_pend),
    .sfs_q   (sfs_q),
    .a1s_q   (a1s_q)
  );

  rtc_subsec_cnt #(.CNT_W(CNT_W)) cnt_i (
    .clk     (clk),
    .sys_rst (sys_rst),
    .bkp_rst (bkp_rst),
    .tick    (tick),
    .reload  (factor_s),
    .pend    (shift_pend),
    .sfs     (sfs_q),
    .a1s     (a1s_q),
    .cnt     (ssc),
    .stb     (sec_stb),
    .add1    (add_sec)
  );

  // R9
  sysrst_keep_chk: assert property (@(posedge clk) disable iff (bkp_rst)
    sys_rst && shift_pend && !tick |=> shift_pend && !sec_stb && !add_sec);
  // R5
  add_pulse_chk: assert property (@(posedge clk) disable iff (bkp_rst || sys_rst)
    add_sec |-> !shift_pend);
endmodule

// File: tb/rtc_subsec_shift_tb_top.sv
module rtc_subsec_shift_tb_top;
  logic        clk = 1'b0;
  logic        sys_rst = 1'b0;
  logic        bkp_rst = 1'b1;
  logic        tick = 1'b0;
  logic [14:0] factor_s = 15'd20;
  logic        ref_en = 1'b0;
  logic        shift_wr = 1'b0;
  logic [14:0] shift_sfs = '0;
  logic        shift_a1s = 1'b0;
  logic [15:0] ssc;
  logic        sec_stb;
  logic        add_sec;
  logic        shift_pend;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rtc_subsec_shift dut_i (
    .clk(clk), .sys_rst(sys_rst), .bkp_rst(bkp_rst), .tick(tick),
    .factor_s(factor_s), .ref_en(ref_en), .shift_wr(shift_wr),
    .shift_sfs(shift_sfs), .shift_a1s(shift_a1s), .ssc(ssc),
    .sec_stb(sec_stb), .add_sec(add_sec), .shift_pend(shift_pend)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_stb();
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!sec_stb && guard < 70000);
  endtask

  // counts negedges until the next strobe; caller is at a negedge
  task automatic count_to_stb(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!sec_stb && n < 70000);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R10", "ssc at reset", ssc, 0);
    check("R10", "pend at reset", shift_pend, 0);
    check("R10", "stb at reset", sec_stb, 0);
    check("R10", "add at reset", add_sec, 0);
    bkp_rst = 1'b0;
    tick = 1'b1;
    @(negedge clk);
    check("R2", "reload after first tick", ssc, 20);
    check("R2", "first strobe", sec_stb, 1);
  endtask

  task automatic t_hold_step();
    wait_stb();
    tick = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "hold without tick", ssc, 20);
    tick = 1'b1;
    @(negedge clk);
    check("R1", "step by one", ssc, 19);
    @(negedge clk);
    check("R1", "second step", ssc, 18);
  endtask

  task automatic t_period(input int f);
    int n;
    factor_s = 15'(f);
    wait_stb();
    count_to_stb(n);
    check("R2", "plain period", n, f + 1);
    check("R2", "reload value", ssc, f);
    @(negedge clk);
    check("R2", "strobe one cycle", sec_stb, 0);
  endtask

  task automatic t_shift(input int sfs, input bit a1s, input string req);
    int n = 0;
    wait_stb();
    shift_wr = 1'b1; shift_sfs = 15'(sfs); shift_a1s = a1s;
    do begin
      @(negedge clk);
      shift_wr = 1'b0;
      n++;
      if (n == 1) check("R3", "pend after write", shift_pend, 1);
      if (n == 2) begin
        check(req, "pend cleared", shift_pend, 0);
        check(req, "add_sec pulse", add_sec, int'(a1s));
      end
      if (n == 3) check(req, "add_sec one cycle", add_sec, 0);
    end while (!sec_stb && n < 70000);
    check(req, "shifted period", n, 21 + sfs);
  endtask

  task automatic t_refen();
    int n = 0;
    wait_stb();
    ref_en = 1'b1;
    shift_wr = 1'b1; shift_sfs = 15'd9;
    @(negedge clk);
    shift_wr = 1'b0;
    check("R6", "pend blocked", shift_pend, 0);
    n = 1;
    while (!sec_stb && n < 70000) begin
      @(negedge clk);
      n++;
    end
    check("R6", "period unchanged", n, 21);
    ref_en = 1'b0;
  endtask

  task automatic t_busy();
    int n = 0;
    wait_stb();
    tick = 1'b0;
    shift_wr = 1'b1; shift_sfs = 15'd5; shift_a1s = 1'b0;
    @(negedge clk);
    shift_sfs = 15'd9;
    @(negedge clk);
    shift_wr = 1'b0;
    check("R8", "still pending", shift_pend, 1);
    tick = 1'b1;
    count_to_stb(n);
    check("R8", "first value applied", n, 26);
  endtask

  task automatic t_sysrst();
    int n = 0;
    wait_stb();
    tick = 1'b0;
    shift_wr = 1'b1; shift_sfs = 15'd4;
    @(negedge clk);
    shift_wr = 1'b0;
    sys_rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R9", "pend kept", shift_pend, 1);
    check("R9", "ssc kept", ssc, 20);
    check("R9", "stb cleared", sec_stb, 0);
    sys_rst = 1'b0;
    tick = 1'b1;
    count_to_stb(n);
    check("R9", "shift applied after reset", n, 25);
  endtask

  task automatic t_msb();
    wait_stb();
    shift_wr = 1'b1; shift_sfs = 15'h7FF0;
    @(negedge clk);
    shift_wr = 1'b0;
    @(negedge clk);
    check("R4", "big add result", ssc, 16'h8002);
    shift_wr = 1'b1; shift_sfs = 15'd3;
    @(negedge clk);
    shift_wr = 1'b0;
    check("R7", "write on high count blocked", shift_pend, 0);
    bkp_rst = 1'b1;
    @(negedge clk);
    bkp_rst = 1'b0;
  endtask

  task automatic t_bkp();
    int n;
    wait_stb();
    shift_wr = 1'b1; shift_sfs = 15'd6;
    @(negedge clk);
    shift_wr = 1'b0;
    bkp_rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R10", "ssc cleared", ssc, 0);
    check("R10", "pend cleared", shift_pend, 0);
    tick = 1'b0;
    bkp_rst = 1'b0;
    @(negedge clk);
    check("R10", "ssc zero after release", ssc, 0);
    tick = 1'b1;
    @(negedge clk);
    check("R10", "reload after release", ssc, 20);
    check("R10", "strobe after release", sec_stb, 1);
    count_to_stb(n);
    check("R10", "stored shift discarded", n, 21);
  endtask

  initial begin
    t_reset();
    t_hold_step();
    t_period(20);
    t_period(7);
    t_period(20);
    t_shift(5, 1'b0, "R4");
    t_shift(3, 1'b1, "R5");
    t_shift(0, 1'b1, "R5");
    t_refen();
    t_busy();
    t_sysrst();
    t_msb();
    t_bkp();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule